// File: doc/BRIEF.md
# Select-Synchronised SPI Slave

This block is the receive/transmit engine of an SPI slave. It exchanges 8-bit words most significant bit first. The remote master supplies the serial clock, and an active-low select line gates the exchange. The serial clock, the select line and the serial data input are each brought into the system clock domain through two-flop synchronisers. Clock edges are detected in that domain, so the system clock must run at least four times faster than the serial clock.

Local logic loads the next outgoing word through a write strobe. It collects each incoming word from a receive buffer and acknowledges it with a read strobe. A byte-complete flag, cleared by its own strobe, marks the end of each word. Three static controls shape the link:

- a clock polarity bit, which sets the idle level of the serial clock;
- an edge select bit, which chooses which serial clock edge launches data and which edge captures it;
- a 4-bit mode code, which chooses whether the select line gates the block or is ignored.

Two sticky error flags catch misuse. One marks a word lost to an unread buffer. The other marks a transmit write that lands during a word. A combinational flag marks an illegal mode and edge combination.

Top module: `spi_sel_slave`

## Requirements
- R1: With `cfg_edge`=0, a word is captured on the serial clock transitions that leave the idle level and shifted out on the transitions that return to it, MSB first. The MSB of the loaded transmit word is on `sdo` as soon as the block is selected, before any clock edge.
- R2: With `cfg_edge`=1, `sdo` stays 0 after selection until the first transition away from idle. Each bit is launched on a transition away from idle and captured on the transition back to idle, MSB first.
- R3: When the eighth bit is captured, the word appears on `rx_data` and `irq` goes to 1. `irq` stays 1 until `irq_clr` is pulsed.
- R4: `cfg_idle_hi`=1 makes high the idle serial clock level (and low the active level). Transfers then work exactly as with a low idle level, with the edge roles swapped accordingly.
- R5: With `cfg_mode`=4'b0100, words move only while `ss_n` is 0. `sdo_oe` is 1 only while the block is enabled and `ss_n` is 0, and it follows `ss_n` combinationally.
- R6: With `cfg_mode`=4'b0101, `ss_n` is ignored. Words move and `sdo_oe` is 1 whenever `enable` is 1.
- R7: Raising `ss_n` in mode 4'b0100, or clearing `enable`, in the middle of a word abandons it. No `irq` results, and the next word starts again at its first bit.
- R8: `cfg_err` is 1 whenever `enable`=1, `cfg_mode`=4'b0101 and `cfg_edge`=1. While it is 1, `sdo_oe` is 0 and no word is received.
- R9: If a word completes while the previous one has not been read (no `rx_rd` since it arrived), `rx_ovf` goes to 1 and `rx_data` keeps the older word. `rx_ovf` holds until `err_clr` is pulsed.
- R10: A `tx_wr` pulse during a word sets `wr_col` and is ignored: the word in flight and the word sent next are unchanged. `wr_col` holds until `err_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 abandons any word in progress |
| cfg_mode | input | 4 | 4'b0100 select-gated slave, 4'b0101 select ignored, other codes inert |
| cfg_idle_hi | input | 1 | Serial clock idle level |
| cfg_edge | input | 1 | Edge select: 0 capture leaving idle, 1 launch leaving idle |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (0 while not enabled for output) |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| tx_data | input | 8 | Next word to transmit |
| tx_wr | input | 1 | Write strobe for tx_data |
| rx_data | output | 8 | Last received word |
| rx_rd | input | 1 | Read acknowledge for rx_data |
| irq | output | 1 | Byte-complete flag |
| irq_clr | input | 1 | Clears irq |
| rx_ovf | output | 1 | Sticky receive overflow |
| wr_col | output | 1 | Sticky write collision |
| err_clr | input | 1 | Clears rx_ovf and wr_col |
| cfg_err | output | 1 | Illegal configuration indicator |

## Verification
Several properties are checked on every cycle:

- a select-high or disabled state leaves the bit counter at zero on the next cycle;
- a rising byte-complete flag is always preceded by the last bit index;
- an overflowing completion leaves the receive buffer unchanged;
- a colliding write leaves the transmit buffer unchanged;
- an illegal configuration never leaves a word in progress.

Other behaviour is shown only by the bench's scenarios:

- the bit order and edge roles under both edge settings and both clock polarities;
- the held-low output before the first edge;
- the immediate output release when select rises;
- a clean restart after an abandoned word.

// File: rtl/spi_sel_slave.sv
module spi_sel_slave #(
  parameter int          DW        = 8,
  parameter logic [3:0]  MODE_SEL  = 4'b0100,
  parameter logic [3:0]  MODE_FREE = 4'b0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [3:0]    cfg_mode,
  input  logic          cfg_idle_hi,
  input  logic          cfg_edge,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_wr,
  output logic [DW-1:0] rx_data,
  input  logic          rx_rd,
  output logic          irq,
  input  logic          irq_clr,
  output logic          rx_ovf,
  output logic          wr_col,
  input  logic          err_clr,
  output logic          cfg_err
);

  localparam int            CW       = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  logic [2:0]    sck_q;
  logic [1:0]    ss_q;
  logic [1:0]    sdi_q;
  logic [CW-1:0] cnt;
  logic          act;
  logic [DW-1:0] rx_sh, tx_sh, tx_buf, rx_buf, rx_word;
  logic          rx_full;
  logic          sel_mode, free_mode, run;
  logic          sck_act, sck_was, lead, trail;
  logic          samp, shft, start, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      ss_q  <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      ss_q  <= {ss_q[0], ss_n};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  assign sel_mode  = (cfg_mode == MODE_SEL);
  assign free_mode = (cfg_mode == MODE_FREE);
  assign cfg_err   = enable && free_mode && cfg_edge;
  assign run       = enable && !cfg_err && (free_mode || (sel_mode && !ss_q[1]));

  assign sck_act = sck_q[1] ^ cfg_idle_hi;
  assign sck_was = sck_q[2] ^ cfg_idle_hi;
  assign lead    = sck_act && !sck_was;
  assign trail   = !sck_act && sck_was;

  assign samp    = run && (cfg_edge ? trail : lead);
  assign shft    = run && act && (cfg_edge ? lead : trail);
  assign start   = run && !act && cfg_edge && lead;
  assign last    = samp && (cnt == LAST_IDX);
  assign rx_word = {rx_sh[DW-2:0], sdi_q[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      act   <= 1'b0;
      rx_sh <= '0;
      tx_sh <= '0;
    end else if (!run) begin
      cnt   <= '0;
      act   <= 1'b0;
      tx_sh <= tx_buf;
    end else begin
      if (samp) begin
        rx_sh <= rx_word;
        cnt   <= last ? '0 : cnt + CW'(1);
      end
      if (last)               act <= 1'b0;
      else if (samp || start) act <= 1'b1;
      if (!act)      tx_sh <= tx_buf;
      else if (shft) tx_sh <= {tx_sh[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      rx_buf  <= '0;
      rx_full <= 1'b0;
      irq     <= 1'b0;
      rx_ovf  <= 1'b0;
      wr_col  <= 1'b0;
    end else begin
      if (err_clr) begin
        rx_ovf <= 1'b0;
        wr_col <= 1'b0;
      end
      if (tx_wr) begin
        if (act) wr_col <= 1'b1;
        else     tx_buf <= tx_data;
      end
      if (irq_clr) irq     <= 1'b0;
      if (rx_rd)   rx_full <= 1'b0;
      if (last) begin
        irq <= 1'b1;
        if (rx_full) rx_ovf <= 1'b1;
        else begin
          rx_buf  <= rx_word;
          rx_full <= 1'b1;
        end
      end
    end
  end

  assign rx_data = rx_buf;
  assign sdo_oe  = enable && !cfg_err && (free_mode || (sel_mode && !ss_n));
  assign sdo     = sdo_oe && !(cfg_edge && !act) && tx_sh[DW-1];

  // R7
  abort_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || (sel_mode && ss_q[1])) |=> (cnt == '0 && !act));

  // R3
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt) == LAST_IDX && $past(run)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && rx_full) |=> (rx_ovf && $stable(rx_data)));

  // R10
  wr_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && act) |=> (wr_col && $stable(tx_buf)));

  // R8
  cfg_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !act);

endmodule

// File: tb/spi_sel_slave_tb_top.sv
module spi_sel_slave_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       enable = 0;
  logic [3:0] cfg_mode = 4'b0100;
  logic       cfg_idle_hi = 0, cfg_edge = 0;
  logic       sck = 0, ss_n = 1, sdi = 0;
  logic       sdo, sdo_oe;
  logic [7:0] tx_data = 0;
  logic       tx_wr = 0;
  logic [7:0] rx_data;
  logic       rx_rd = 0, irq_clr = 0, err_clr = 0;
  logic       irq, rx_ovf, wr_col, cfg_err;

  int n_chk = 0, n_bad = 0;
  bit mon_on = 1;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  spi_sel_slave dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mode(cfg_mode),
    .cfg_idle_hi(cfg_idle_hi), .cfg_edge(cfg_edge), .sck(sck), .ss_n(ss_n),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .tx_data(tx_data), .tx_wr(tx_wr),
    .rx_data(rx_data), .rx_rd(rx_rd), .irq(irq), .irq_clr(irq_clr),
    .rx_ovf(rx_ovf), .wr_col(wr_col), .err_clr(err_clr), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, a, e);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tx(input logic [7:0] v);
    @(negedge clk); tx_data = v; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic bit_x(input logic b, output logic s);
    if (!cfg_edge) begin
      sdi = b; wait_clk(8); s = sdo;
      sck = ~cfg_idle_hi; wait_clk(8);
      sck = cfg_idle_hi;
    end else begin
      sck = ~cfg_idle_hi; sdi = b; wait_clk(8); s = sdo;
      sck = cfg_idle_hi; wait_clk(8);
    end
  endtask

  task automatic xfer(input logic [7:0] mosi, input logic [7:0] miso, input bit push,
                      input bit chk_miso, input string req);
    logic [7:0] got;
    logic s;
    if (push) exp_q.push_back(mosi);
    for (int i = 7; i >= 0; i--) begin
      bit_x(mosi[i], s);
      got[i] = s;
    end
    wait_clk(10);
    if (chk_miso) chk(got == miso, req, got, miso);
  endtask

  task automatic set_cfg(input logic [3:0] m, input logic idle, input logic e);
    @(negedge clk); enable = 0;
    cfg_mode = m; cfg_idle_hi = idle; cfg_edge = e; sck = idle;
    wait_clk(5);
    enable = 1;
    wait_clk(2);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && irq) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R3 received byte", rx_data, e);
        end
        rx_rd = 1; irq_clr = 1;
        @(negedge clk);
        rx_rd = 0; irq_clr = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic s;
    logic [7:0] got;
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    chk(sdo_oe == 0, "R5 reset oe", sdo_oe, 0);
    chk(irq == 0, "R3 reset irq", irq, 0);
    chk({rx_ovf, wr_col, cfg_err} == 0, "R9 reset flags", {rx_ovf, wr_col, cfg_err}, 0);

    // R1 / R5: select-gated, low idle, edge 0
    set_cfg(4'b0100, 0, 0);
    wr_tx(8'hBC);
    wait_clk(2);
    chk(sdo_oe == 0, "R5 oe off while deselected", sdo_oe, 0);
    ss_n = 0; #1;
    chk(sdo_oe == 1, "R5 oe on when selected", sdo_oe, 1);
    wait_clk(3);
    chk(sdo == 1, "R1 MSB present before first edge", sdo, 1);
    xfer(8'hA5, 8'hBC, 1, 1, "R1 tx word edge0");
    wr_tx(8'hF0);
    xfer(8'h00, 8'hF0, 1, 1, "R1 tx word edge0 second");
    @(negedge clk); ss_n = 1; #1;
    chk(sdo_oe == 0, "R5 oe off after deselect", sdo_oe, 0);

    // R4: high idle
    set_cfg(4'b0100, 1, 0);
    wr_tx(8'h81);
    ss_n = 0;
    wait_clk(3);
    xfer(8'h7E, 8'h81, 1, 1, "R4 high idle tx word");
    ss_n = 1;

    // R2: edge 1
    set_cfg(4'b0100, 1, 1);
    wr_tx(8'hC3);
    ss_n = 0;
    wait_clk(4);
    chk(sdo == 0 && sdo_oe == 1, "R2 sdo held low before first edge", {sdo, sdo_oe}, 2'b01);
    xfer(8'h5A, 8'hC3, 1, 1, "R2 tx word edge1");
    wr_tx(8'h00);
    xfer(8'hFF, 8'h00, 1, 1, "R2 tx word edge1 second");
    ss_n = 1;

    // R7: select abort
    set_cfg(4'b0100, 0, 0);
    wr_tx(8'hB4);
    ss_n = 0;
    wait_clk(3);
    for (int i = 0; i < 3; i++) bit_x(1'b1, s);
    @(negedge clk); ss_n = 1; #1;
    chk(sdo_oe == 0, "R5 oe released at once mid-word", sdo_oe, 0);
    wait_clk(10);
    chk(irq == 0, "R7 no irq after abort", irq, 0);
    ss_n = 0;
    wait_clk(3);
    xfer(8'hC6, 8'hB4, 1, 1, "R7 fresh word after abort");
    ss_n = 1;

    // R6: free mode, select ignored; R7 enable abort
    set_cfg(4'b0101, 0, 0);
    ss_n = 1;
    wr_tx(8'h69);
    wait_clk(2);
    chk(sdo_oe == 1, "R6 oe with select high", sdo_oe, 1);
    xfer(8'h2D, 8'h69, 1, 1, "R6 word with select ignored");
    for (int i = 0; i < 3; i++) bit_x(1'b0, s);
    @(negedge clk); enable = 0;
    wait_clk(5);
    enable = 1;
    wait_clk(5);
    chk(irq == 0, "R7 no irq after disable", irq, 0);
    xfer(8'hE1, 8'h69, 1, 1, "R7 fresh word after disable");

    // R8: illegal config
    @(negedge clk); cfg_edge = 1; #1;
    chk(cfg_err == 1, "R8 cfg_err set", cfg_err, 1);
    chk(sdo_oe == 0, "R8 oe off when illegal", sdo_oe, 0);
    xfer(8'h99, 8'h00, 0, 0, "R8");
    chk(irq == 0, "R8 no word received", irq, 0);
    @(negedge clk); cfg_edge = 0; #1;
    chk(cfg_err == 0, "R8 cfg_err clear", cfg_err, 0);

    // R9: overflow
    set_cfg(4'b0100, 0, 0);
    mon_on = 0;
    wr_tx(8'h00);
    ss_n = 0;
    wait_clk(3);
    xfer(8'h11, 8'h00, 0, 0, "R9");
    chk(rx_ovf == 0, "R9 no overflow on first word", rx_ovf, 0);
    xfer(8'h22, 8'h00, 0, 0, "R9");
    chk(rx_ovf == 1, "R9 overflow set", rx_ovf, 1);
    chk(rx_data == 8'h11, "R9 old word kept", rx_data, 8'h11);
    chk(irq == 1, "R3 irq held until cleared", irq, 1);
    @(negedge clk); rx_rd = 1; irq_clr = 1; err_clr = 1;
    @(negedge clk); rx_rd = 0; irq_clr = 0; err_clr = 0;
    chk(rx_ovf == 0 && irq == 0, "R9 flags cleared", {rx_ovf, irq}, 0);
    mon_on = 1;
    ss_n = 1;

    // R10: write collision
    wr_tx(8'h96);
    ss_n = 0;
    wait_clk(3);
    exp_q.push_back(8'hC3);
    for (int i = 7; i >= 0; i--) begin
      bit_x(8'hC3 >> i, s);
      got[i] = s;
      if (i == 5) wr_tx(8'h11);
    end
    wait_clk(10);
    chk(got == 8'h96, "R10 word in flight unchanged", got, 8'h96);
    chk(wr_col == 1, "R10 collision flagged", wr_col, 1);
    ss_n = 1;
    wait_clk(4);
    ss_n = 0;
    wait_clk(3);
    xfer(8'h3C, 8'h96, 1, 1, "R10 ignored write left buffer");
    ss_n = 1;
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk(wr_col == 0, "R10 collision cleared", wr_col, 0);

    wait_clk(10);
    chk(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);
    finish_up();
  end
endmodule